// File: doc/BRIEF.md
# Dual-Clock FIFO Channel with Fall-Through Option

This block is one FIFO channel that carries 10-bit words from a write clock domain into an unrelated read clock domain. Each side has its own enable and its own flags. The write side reports full and almost-full. The read side reports empty, almost-empty and a data-valid flag. The write and read pointers cross between the domains as Gray code through two-flop synchronizers, so each flag is computed only from state that is local to its own domain.

The output timing is chosen while master reset is held, and the two almost-flag thresholds are captured at the same time. In standard timing, a word appears one read-clock cycle after an accepted read. In fall-through timing, the oldest word waits on the output with the valid flag high, and the read enable only consumes it. A partial reset empties the channel by clearing both pointers. It keeps the captured timing mode and thresholds.

Top module: `cdc_fifo_channel`

## Requirements
- R1: While master reset is held and after it is released, rdEmpty and rdAlmostEmpty are 1, and wrFull, wrAlmostFull and rdValid are 0.
- R2: In standard timing, an accepted read (rdEn=1 while rdEmpty=0) puts the oldest word on rdData with rdValid=1 one rdClk cycle later. Words leave in the order they were written, and rdValid is 0 in the cycle after a clock edge with no accepted read.
- R3: wrFull is 1 when DEPTH words are stored. A write while wrFull=1 stores nothing, so the DEPTH words read back afterwards are the original ones and the channel is then empty.
- R4: A read while the channel is empty returns no data (rdValid stays 0) and leaves the read pointer unchanged, so later words come out correctly.
- R5: In fall-through timing, the oldest stored word is on rdData with rdValid=1 without any read. rdEn=1 for one cycle replaces it with the next word, and rdEmpty equals the inverse of rdValid.
- R6: rdAlmostEmpty is 1 when the read-side word count is at or below the captured empty threshold. In fall-through timing, the word shown on the output counts toward the word count.
- R7: wrAlmostFull is 1 when DEPTH minus the write-side word count is at or below the captured full threshold.
- R8: While master reset is held, the timing mode is captured from cfgFallThru (1 = fall-through, 0 = standard). Each threshold takes its pin value when cfgOfsLoad=1 and 8 otherwise. Changes on these pins after release have no effect.
- R9: A partial reset empties the channel in both domains (same flag values as R1) and keeps the captured timing mode and thresholds.
- R10: The Gray-coded pointer sent into the other domain changes in at most one bit per source clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-side clock |
| rdClk | input | 1 | Read-side clock, independent of wrClk |
| mstReset | input | 1 | Master reset, active high; clears pointers and captures configuration |
| partReset | input | 1 | Partial reset, active high; clears pointers only |
| cfgFallThru | input | 1 | Timing mode captured at master reset: 1 fall-through, 0 standard |
| cfgOfsLoad | input | 1 | At master reset, 1 takes thresholds from pins, 0 uses 8 |
| cfgAeOfs | input | PTR_W | Almost-empty threshold pin |
| cfgAfOfs | input | PTR_W | Almost-full threshold pin |
| wrEn | input | 1 | Write enable |
| wrData | input | DATA_W | Write data |
| wrFull | output | 1 | Channel full (write domain) |
| wrAlmostFull | output | 1 | Free space at or below threshold (write domain) |
| rdEn | input | 1 | Read enable |
| rdData | output | DATA_W | Read data |
| rdValid | output | 1 | rdData holds a word delivered to the reader |
| rdEmpty | output | 1 | No word available (read domain) |
| rdAlmostEmpty | output | 1 | Word count at or below threshold (read domain) |

## Verification
On every clock of its domain, the assertions check these properties:
- The stored word count never goes past DEPTH.
- An empty channel never moves the read pointer.
- The Gray pointers step in at most one bit per edge.
- Full implies almost-full, and empty implies almost-empty.
- An accepted standard read is followed by valid data, and fall-through timing refills an empty output whenever words are stored.

Only the bench scenarios can show the values and order of the data, the exact threshold crossings, and that configuration survives a partial reset while later pin changes are ignored.

// File: rtl/fifo_ch_pkg.sv
package fifo_ch_pkg;

  // strobes from the two control halves to the storage datapath
  typedef struct packed {
    logic memWr;   // store wrData at the write address
    logic memRd;   // load the output register from the read address
  } fifoStrobe_t;

  localparam int unsigned DEF_OFS = 8;

endpackage

// File: rtl/fifo_gray_sync.sv
module fifo_gray_sync #(
  parameter int unsigned W = 5
) (
  input  logic         dstClk,
  input  logic         rst,
  input  logic [W-1:0] grayIn,
  output logic [W-1:0] binOut
);

  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  always_ff @(posedge dstClk or posedge rst) begin
    if (rst) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= grayIn;
      stage2 <= stage1;
    end
  end

  always_comb begin
    binOut[W-1] = stage2[W-1];
    for (int i = W - 2; i >= 0; i--) begin
      binOut[i] = binOut[i+1] ^ stage2[i];
    end
  end

endmodule

// File: rtl/fifo_wr_ctrl.sv
module fifo_wr_ctrl #(
  parameter int unsigned DEPTH  = 1024,
  parameter int unsigned PTR_W  = $clog2(DEPTH) + 1,
  parameter int unsigned DEF_AF = 8
) (
  input  logic             wrClk,
  input  logic             rstAny,
  input  logic             mstReset,
  input  logic             cfgOfsLoad,
  input  logic [PTR_W-1:0] cfgAfOfs,
  input  logic             wrEn,
  input  logic [PTR_W-1:0] rdGray,
  output logic [PTR_W-1:0] wrGray,
  output logic [PTR_W-2:0] wrAddr,
  output logic             memWr,
  output logic             wrFull,
  output logic             wrAlmostFull
);

  localparam logic [PTR_W-1:0] DEPTH_V = PTR_W'(DEPTH);

  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] wrPtrNext;
  logic [PTR_W-1:0] rdPtrSync;
  logic [PTR_W-1:0] usedCnt;
  logic [PTR_W-1:0] freeCnt;
  logic [PTR_W-1:0] afOfs;

  fifo_gray_sync #(.W(PTR_W)) u_rdSync (
    .dstClk (wrClk),
    .rst    (rstAny),
    .grayIn (rdGray),
    .binOut (rdPtrSync)
  );

  // thresholds are captured only while master reset is held
  always_ff @(posedge wrClk) begin
    if (mstReset) afOfs <= cfgOfsLoad ? cfgAfOfs : PTR_W'(DEF_AF);
  end

  assign usedCnt      = wrPtr - rdPtrSync;
  assign freeCnt      = DEPTH_V - usedCnt;
  assign wrFull       = (usedCnt == DEPTH_V);
  assign wrAlmostFull = (freeCnt <= afOfs);
  assign memWr        = wrEn && !wrFull;
  assign wrPtrNext    = wrPtr + PTR_W'(memWr);
  assign wrAddr       = wrPtr[PTR_W-2:0];

  always_ff @(posedge wrClk or posedge rstAny) begin
    if (rstAny) begin
      wrPtr  <= '0;
      wrGray <= '0;
    end else begin
      wrPtr  <= wrPtrNext;
      wrGray <= wrPtrNext ^ (wrPtrNext >> 1);
    end
  end

  p_used_bound_r3: assert property (@(posedge wrClk) disable iff (rstAny)
    usedCnt <= DEPTH_V);

  p_full_implies_af_r7: assert property (@(posedge wrClk) disable iff (rstAny)
    wrFull |-> wrAlmostFull);

  p_gray_step_r10: assert property (@(posedge wrClk) disable iff (rstAny)
    $countones(wrGray ^ $past(wrGray)) <= 1);

  p_full_blocks_ptr_r3: assert property (@(posedge wrClk) disable iff (rstAny)
    wrFull |=> (wrPtr == $past(wrPtr)));

endmodule

// File: rtl/fifo_rd_ctrl.sv
module fifo_rd_ctrl #(
  parameter int unsigned DEPTH  = 1024,
  parameter int unsigned PTR_W  = $clog2(DEPTH) + 1,
  parameter int unsigned DEF_AE = 8
) (
  input  logic             rdClk,
  input  logic             rstAny,
  input  logic             mstReset,
  input  logic             cfgFallThru,
  input  logic             cfgOfsLoad,
  input  logic [PTR_W-1:0] cfgAeOfs,
  input  logic             rdEn,
  input  logic [PTR_W-1:0] wrGray,
  output logic [PTR_W-1:0] rdGray,
  output logic [PTR_W-2:0] rdAddr,
  output logic             memRd,
  output logic             rdValid,
  output logic             rdEmpty,
  output logic             rdAlmostEmpty
);

  logic [PTR_W-1:0] rdPtr;
  logic [PTR_W-1:0] rdPtrNext;
  logic [PTR_W-1:0] wrPtrSync;
  logic [PTR_W-1:0] wordCnt;
  logic [PTR_W-1:0] aeOfs;
  logic             fallThru;
  logic             memEmpty;
  logic             outValid;
  logic             outValidNext;

  fifo_gray_sync #(.W(PTR_W)) u_wrSync (
    .dstClk (rdClk),
    .rst    (rstAny),
    .grayIn (wrGray),
    .binOut (wrPtrSync)
  );

  always_ff @(posedge rdClk) begin
    if (mstReset) begin
      fallThru <= cfgFallThru;
      aeOfs    <= cfgOfsLoad ? cfgAeOfs : PTR_W'(DEF_AE);
    end
  end

  assign memEmpty = (rdPtr == wrPtrSync);

  always_comb begin
    if (fallThru) begin
      memRd        = !memEmpty && (!outValid || rdEn);
      outValidNext = memRd || (outValid && !rdEn);
      rdEmpty      = !outValid;
      wordCnt      = (wrPtrSync - rdPtr) + PTR_W'(outValid);
    end else begin
      memRd        = rdEn && !memEmpty;
      outValidNext = memRd;
      rdEmpty      = memEmpty;
      wordCnt      = wrPtrSync - rdPtr;
    end
  end

  assign rdAlmostEmpty = (wordCnt <= aeOfs);
  assign rdValid       = outValid;
  assign rdPtrNext     = rdPtr + PTR_W'(memRd);
  assign rdAddr        = rdPtr[PTR_W-2:0];

  always_ff @(posedge rdClk or posedge rstAny) begin
    if (rstAny) begin
      rdPtr    <= '0;
      rdGray   <= '0;
      outValid <= 1'b0;
    end else begin
      rdPtr    <= rdPtrNext;
      rdGray   <= rdPtrNext ^ (rdPtrNext >> 1);
      outValid <= outValidNext;
    end
  end

  p_no_underflow_r4: assert property (@(posedge rdClk) disable iff (rstAny)
    memEmpty |=> (rdPtr == $past(rdPtr)));

  p_std_latency_r2: assert property (@(posedge rdClk) disable iff (rstAny)
    (!fallThru && rdEn && !rdEmpty) |=> rdValid);

  p_fwft_refill_r5: assert property (@(posedge rdClk) disable iff (rstAny)
    (fallThru && !rdValid && !memEmpty) |=> rdValid);

  p_empty_implies_ae_r6: assert property (@(posedge rdClk) disable iff (rstAny)
    rdEmpty |-> rdAlmostEmpty);

  p_gray_step_rd_r10: assert property (@(posedge rdClk) disable iff (rstAny)
    $countones(rdGray ^ $past(rdGray)) <= 1);

endmodule

// File: rtl/fifo_datapath.sv
module fifo_datapath
  import fifo_ch_pkg::*;
#(
  parameter int unsigned DEPTH  = 1024,
  parameter int unsigned DATA_W = 10,
  parameter int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstAny,
  input  fifoStrobe_t       stb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge wrClk) begin
    if (stb.memWr) store[wrAddr] <= wrData;
  end

  always_ff @(posedge rdClk or posedge rstAny) begin
    if (rstAny)         rdData <= '0;
    else if (stb.memRd) rdData <= store[rdAddr];
  end

endmodule

// File: rtl/cdc_fifo_channel.sv
module cdc_fifo_channel
  import fifo_ch_pkg::*;
#(
  parameter int unsigned DEPTH  = 1024,
  parameter int unsigned DATA_W = 10,
  parameter int unsigned DEF_AE = DEF_OFS,
  parameter int unsigned DEF_AF = DEF_OFS,
  localparam int unsigned ADDR_W = $clog2(DEPTH),
  localparam int unsigned PTR_W  = ADDR_W + 1
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              mstReset,
  input  logic              partReset,
  input  logic              cfgFallThru,
  input  logic              cfgOfsLoad,
  input  logic [PTR_W-1:0]  cfgAeOfs,
  input  logic [PTR_W-1:0]  cfgAfOfs,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic              wrFull,
  output logic              wrAlmostFull,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              rdEmpty,
  output logic              rdAlmostEmpty
);

  logic              rstAny;
  logic [PTR_W-1:0]  wrGray;
  logic [PTR_W-1:0]  rdGray;
  logic [ADDR_W-1:0] wrAddr;
  logic [ADDR_W-1:0] rdAddr;
  logic              wrStb;
  logic              rdStb;
  fifoStrobe_t       stb;

  assign rstAny = mstReset | partReset;
  assign stb    = '{memWr: wrStb, memRd: rdStb};

  fifo_wr_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .DEF_AF(DEF_AF)) u_wr (
    .wrClk        (wrClk),
    .rstAny       (rstAny),
    .mstReset     (mstReset),
    .cfgOfsLoad   (cfgOfsLoad),
    .cfgAfOfs     (cfgAfOfs),
    .wrEn         (wrEn),
    .rdGray       (rdGray),
    .wrGray       (wrGray),
    .wrAddr       (wrAddr),
    .memWr        (wrStb),
    .wrFull       (wrFull),
    .wrAlmostFull (wrAlmostFull)
  );

  fifo_rd_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .DEF_AE(DEF_AE)) u_rd (
    .rdClk         (rdClk),
    .rstAny        (rstAny),
    .mstReset      (mstReset),
    .cfgFallThru   (cfgFallThru),
    .cfgOfsLoad    (cfgOfsLoad),
    .cfgAeOfs      (cfgAeOfs),
    .rdEn          (rdEn),
    .wrGray        (wrGray),
    .rdGray        (rdGray),
    .rdAddr        (rdAddr),
    .memRd         (rdStb),
    .rdValid       (rdValid),
    .rdEmpty       (rdEmpty),
    .rdAlmostEmpty (rdAlmostEmpty)
  );

  fifo_datapath #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .wrClk  (wrClk),
    .rdClk  (rdClk),
    .rstAny (rstAny),
    .stb    (stb),
    .wrAddr (wrAddr),
    .rdAddr (rdAddr),
    .wrData (wrData),
    .rdData (rdData)
  );

  p_reset_flags_r1: assert property (@(posedge rdClk)
    mstReset |=> (rdEmpty && !rdValid));

endmodule

// File: tb/sim_cdc_fifo_channel.sv
module sim_cdc_fifo_channel;

  localparam int unsigned DEPTH = 16;
  localparam int unsigned DW    = 10;
  localparam int unsigned PW    = $clog2(DEPTH) + 1;

  logic          wrClk = 1'b0;
  logic          rdClk = 1'b0;
  logic          mstReset = 1'b1;
  logic          partReset = 1'b0;
  logic          cfgFallThru = 1'b0;
  logic          cfgOfsLoad = 1'b0;
  logic [PW-1:0] cfgAeOfs = '0;
  logic [PW-1:0] cfgAfOfs = '0;
  logic          wrEn = 1'b0;
  logic [DW-1:0] wrData = '0;
  logic          rdEn = 1'b0;
  logic          wrFull, wrAlmostFull, rdValid, rdEmpty, rdAlmostEmpty;
  logic [DW-1:0] rdData;

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 wrClk = ~wrClk;   // 50 MHz write clock
  always #13 rdClk = ~rdClk;   // unrelated read clock

  cdc_fifo_channel #(.DEPTH(DEPTH), .DATA_W(DW)) u0 (
    .wrClk, .rdClk, .mstReset, .partReset, .cfgFallThru, .cfgOfsLoad,
    .cfgAeOfs, .cfgAfOfs, .wrEn, .wrData, .wrFull, .wrAlmostFull,
    .rdEn, .rdData, .rdValid, .rdEmpty, .rdAlmostEmpty
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic masterReset(input bit ft, input bit ld, input int ae, input int af);
    @(negedge wrClk);
    cfgFallThru = ft; cfgOfsLoad = ld;
    cfgAeOfs = PW'(ae); cfgAfOfs = PW'(af);
    mstReset = 1'b1;
    #200;
    @(negedge wrClk);
    mstReset = 1'b0;
    // later pin changes must not matter
    cfgFallThru = ~ft; cfgOfsLoad = ~ld;
    cfgAeOfs = '1; cfgAfOfs = '1;
    #100;
  endtask

  task automatic settle();
    #300;
  endtask

  task automatic push(input int d);
    @(negedge wrClk);
    wrEn = 1'b1; wrData = DW'(d);
    @(negedge wrClk);
    wrEn = 1'b0;
  endtask

  task automatic pull();
    @(negedge rdClk);
    rdEn = 1'b1;
    @(negedge rdClk);
    rdEn = 1'b0;
  endtask

  task automatic stdRead(input string req, input int exp);
    pull();
    chk(req, rdValid, 1);
    chk(req, rdData, exp);
  endtask

  task automatic t_reset();
    masterReset(1'b0, 1'b0, 0, 0);
    chk("R1 empty", rdEmpty, 1);
    chk("R1 almostEmpty", rdAlmostEmpty, 1);
    chk("R1 full", wrFull, 0);
    chk("R1 almostFull", wrAlmostFull, 0);
    chk("R1 valid", rdValid, 0);
  endtask

  task automatic t_underflow();
    pull();
    chk("R4 valid after empty read", rdValid, 0);
    push(10'h155);
    settle();
    stdRead("R4 data after empty read", 10'h155);
    @(negedge rdClk);
    chk("R4 empty again", rdEmpty, 1);
  endtask

  task automatic t_std_order();
    for (int i = 0; i < 5; i++) push(10'h0A0 + i * 7);
    settle();
    chk("R2 not empty", rdEmpty, 0);
    chk("R2 no data without read", rdValid, 0);
    for (int i = 0; i < 5; i++) stdRead("R2 order", 10'h0A0 + i * 7);
    @(negedge rdClk);
    chk("R2 valid drops", rdValid, 0);
    chk("R2 empty after drain", rdEmpty, 1);
  endtask

  task automatic t_default_thresholds();
    for (int i = 0; i < 7; i++) push(10'h200 + i);
    chk("R7 R8 af free 9", wrAlmostFull, 0);
    push(10'h207);
    chk("R7 R8 af free 8", wrAlmostFull, 1);
    settle();
    chk("R6 R8 ae count 8", rdAlmostEmpty, 1);
    push(10'h208);
    settle();
    chk("R6 R8 ae count 9", rdAlmostEmpty, 0);
    for (int i = 9; i < 16; i++) push(10'h200 + i);
    chk("R3 full", wrFull, 1);
    push(10'h3FF);
    chk("R3 still full", wrFull, 1);
    settle();
    for (int i = 0; i < 16; i++) stdRead("R3 contents", 10'h200 + i);
    @(negedge rdClk);
    chk("R3 extra write dropped", rdEmpty, 1);
    settle();
    chk("R3 full clears", wrFull, 0);
  endtask

  task automatic t_fallthru();
    masterReset(1'b1, 1'b0, 0, 0);
    chk("R5 R1 empty", rdEmpty, 1);
    chk("R5 R1 valid", rdValid, 0);
    push(10'h0C1); push(10'h0C2); push(10'h0C3);
    settle();
    chk("R5 shown without read", rdValid, 1);
    chk("R5 first word", rdData, 10'h0C1);
    chk("R5 empty inverse", rdEmpty, 0);
    chk("R6 ae counts output word", rdAlmostEmpty, 1);
    pull();
    chk("R5 second word", rdData, 10'h0C2);
    pull();
    chk("R5 third word", rdData, 10'h0C3);
    chk("R5 valid", rdValid, 1);
    pull();
    chk("R5 valid after drain", rdValid, 0);
    chk("R5 empty after drain", rdEmpty, 1);
  endtask

  task automatic t_custom_and_partial();
    masterReset(1'b0, 1'b1, 2, 3);
    push(1); push(2);
    settle();
    chk("R6 R8 ae count 2", rdAlmostEmpty, 1);
    chk("R8 std mode kept", rdValid, 0);
    push(3);
    settle();
    chk("R6 R8 ae count 3", rdAlmostEmpty, 0);
    for (int i = 4; i <= 12; i++) push(i);
    chk("R7 R8 af free 4", wrAlmostFull, 0);
    push(13);
    chk("R7 R8 af free 3", wrAlmostFull, 1);
    @(negedge wrClk);
    partReset = 1'b1;
    #100;
    @(negedge wrClk);
    partReset = 1'b0;
    #100;
    chk("R9 empty", rdEmpty, 1);
    chk("R9 almostEmpty", rdAlmostEmpty, 1);
    chk("R9 full", wrFull, 0);
    chk("R9 almostFull", wrAlmostFull, 0);
    chk("R9 valid", rdValid, 0);
    push(10'h111); push(10'h112); push(10'h113);
    settle();
    chk("R9 ae threshold kept", rdAlmostEmpty, 0);
    chk("R9 std mode kept", rdValid, 0);
    for (int i = 3; i < 13; i++) push(10'h111 + i);
    chk("R9 af threshold kept", wrAlmostFull, 1);
    settle();
    stdRead("R9 first word after partial reset", 10'h111);
  endtask

  initial begin
    t_reset();
    t_underflow();
    t_std_order();
    t_default_thresholds();
    t_fallthru();
    t_custom_and_partial();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errs++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule